// File: doc/BRIEF.md
# Character Row Pixel Fetcher

This block produces the pixel stream of a character-mapped display, one character cell at a time. A raster controller supplies a start address for the current character row, the scan line within the character (0 to 7), and a strobe for each character position. For every strobe the block reads a tile code and an attribute byte from video RAM. It combines the attribute bank nibble, the code and the scan line into a graphics ROM address, then fetches the low and high bitplane bytes. Finally it sends out four pixels on consecutive clocks, each as an 8-bit palette index.

Video RAM and graphics ROM are synchronous memories with one read port each: read data appears on the clock after the address. Each character takes two reads from each memory, and a character lasts four pixel clocks, so both ports are shared across four-cycle slots. Strobes issued every four cycles therefore give a continuous pixel stream along the row. The first pixel of a character appears five clocks after its strobe. The palette lookup and the raster timing are handled elsewhere.

Top module: `charrow_pixel_fetch`

## Requirements
- R1: While reset is held and after it, until the first character completes, `pix_valid` is 0 and `pix_index` is 0; outside a pixel run `pix_index` is always 0.
- R2: In the strobe cycle `vram_addr` equals (row start + column + 1) modulo 2^13, and `vram_re` is 1. The column is 0 when `row_start` accompanies the strobe, and otherwise the previous strobe's column plus one.
- R3: In the cycle after a strobe, `vram_addr` equals the code offset + 0x1000 modulo 2^13, and this read returns the attribute byte.
- R4: The low-plane ROM address is {0, attribute[3:0], code[7:0], line[2:0]}, issued two cycles after the strobe. The high-plane address is the same value with bit 15 set, issued the cycle after.
- R5: With word W = {high byte, low byte}, pixel n (n = 0..3, left to right) has the 4-bit value {W[n+4], W[n], W[n+12], W[n+8]}, most significant bit first.
- R6: Each palette index carries attribute[7:4] in bits 7..4 and the pixel value in bits 3..0.
- R7: The pixels of a character come out on four consecutive cycles, with `pix_valid` high. The first comes exactly five cycles after the strobe cycle.
- R8: Strobes spaced exactly four cycles apart produce an unbroken pixel stream. Strobes are never closer than four cycles.
- R9: The scan line and the row start are sampled with each strobe. A later change of `line_in` or `row_base` does not affect a character already accepted.
- R10: After column 79 (the last of 80), the next strobe without `row_start` uses column 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| row_base | input | 13 | Video RAM start address of the character row |
| line_in | input | 3 | Scan line within the character |
| row_start | input | 1 | With `char_stb`: first character of a row, column 0 |
| char_stb | input | 1 | Character-position strobe |
| vram_addr | output | 13 | Video RAM read address |
| vram_re | output | 1 | Video RAM read enable |
| vram_rdata | input | 8 | Video RAM read data, one cycle after address |
| rom_addr | output | 16 | Graphics ROM read address |
| rom_re | output | 1 | Graphics ROM read enable |
| rom_rdata | input | 8 | Graphics ROM read data, one cycle after address |
| pix_index | output | 8 | Palette index of the current pixel |
| pix_valid | output | 1 | Pixel output valid |

## Verification
The bench uses the default parameters: a 13-bit video RAM space, an attribute offset of 0x1000, 80 columns and a 3-bit scan line. With these values, row start addresses near 0x1FFF wrap both the code and the attribute offsets. An 81-strobe row reaches the column wrap, and all eight scan lines and all sixteen tile banks can appear. The memory contents are hash functions of the address. Any wrong address, bank bit, plane order or bit shuffle therefore shows up as a different palette index on a specific cycle.

// File: rtl/pf_pkg.sv
package pf_pkg;
    localparam int BYTE_W     = 8;
    localparam int PIX_BITS   = 4;
    localparam int PIX_PER_CH = 4;
    localparam int WORD_W     = 2 * BYTE_W;
    localparam int FETCH_LAT  = 5;
    typedef logic [PIX_PER_CH-1:0][PIX_BITS-1:0] pix_group_t;
endpackage

// File: rtl/pf_addr_gen.sv
module pf_addr_gen #(
    parameter int VA       = 13,
    parameter int COLS     = 80,
    parameter int LW       = 3,
    parameter int CW       = 8,
    parameter int ATTR_OFS = 4096
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [VA-1:0] row_base,
    input  logic [LW-1:0] line_in,
    input  logic          row_start,
    input  logic          char_stb,
    input  logic [7:0]    vram_rdata,
    output logic [VA-1:0] vram_addr,
    output logic          vram_re,
    output logic          attr_vld,
    output logic [7:0]    attr,
    output logic [CW-1:0] code,
    output logic [LW-1:0] line
);
    localparam int COLW = (COLS > 1) ? $clog2(COLS) : 1;
    localparam logic [COLW-1:0] LAST_COL  = COLW'(COLS - 1);
    localparam logic [VA-1:0]   ATTR_STEP = VA'(ATTR_OFS);

    typedef struct packed {
        logic [VA-1:0]   base;
        logic [COLW-1:0] col;
        logic [VA-1:0]   off;
        logic [LW-1:0]   line;
        logic [CW-1:0]   code;
        logic            st1;
        logic            st2;
    } ag_t;

    ag_t q, d;
    logic [COLW-1:0] col_eff;
    logic [VA-1:0]   base_eff;
    logic [VA-1:0]   code_off;

    always_comb begin
        col_eff  = row_start ? '0 : q.col;
        base_eff = row_start ? row_base : q.base;
        code_off = VA'(base_eff + VA'(col_eff) + VA'(1));
        d        = q;
        d.st1    = 1'b0;
        d.st2    = q.st1;
        if (char_stb) begin
            d.base = base_eff;
            d.col  = (col_eff == LAST_COL) ? '0 : COLW'(col_eff + 1'b1);
            d.off  = code_off;
            d.line = line_in;
            d.st1  = 1'b1;
        end
        if (q.st1) begin
            d.code = CW'(vram_rdata);
        end
        vram_addr = char_stb ? code_off : VA'(q.off + ATTR_STEP);
        vram_re   = char_stb | q.st1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign attr_vld = q.st2;
    assign attr     = vram_rdata;
    assign code     = q.code;
    assign line     = q.line;

    assert_stb_spacing_R8: assert property (@(posedge clk) disable iff (!rst_n)
        char_stb |-> (!q.st1 && !q.st2));
    assert_next_column_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (char_stb && !row_start && q.col != '0) |-> (vram_addr == VA'(q.off + VA'(1))));
    assert_attr_offset_R3: assert property (@(posedge clk) disable iff (!rst_n)
        q.st1 |-> (vram_re && vram_addr == VA'($past(vram_addr) + ATTR_STEP)));
    assert_col_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (char_stb && !row_start && q.col == LAST_COL) |=> (q.col == '0));
endmodule

// File: rtl/pf_rom_stage.sv
module pf_rom_stage #(
    parameter int LW     = 3,
    parameter int CW     = 8,
    parameter int BANK_W = 4,
    parameter int PAL_W  = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       attr_vld,
    input  logic [7:0]                 attr,
    input  logic [CW-1:0]              code,
    input  logic [LW-1:0]              line,
    input  logic [7:0]                 rom_rdata,
    output logic [BANK_W+CW+LW:0]      rom_addr,
    output logic                       rom_re,
    output logic                       word_vld,
    output logic [pf_pkg::WORD_W-1:0]  word,
    output logic [PAL_W-1:0]           pal
);
    localparam int TA = BANK_W + CW + LW;
    localparam int RA = TA + 1;

    typedef struct packed {
        logic [TA-1:0]    tile_a;
        logic [PAL_W-1:0] pal;
        logic [7:0]       lo;
        logic             s3;
        logic             s4;
    } rs_t;

    rs_t q, d;
    logic [TA-1:0] tile_now;

    always_comb begin
        tile_now = {attr[BANK_W-1:0], code, line};
        d        = q;
        d.s3     = attr_vld;
        d.s4     = q.s3;
        rom_addr = '0;
        rom_re   = 1'b0;
        if (attr_vld) begin
            d.tile_a = tile_now;
            d.pal    = attr[7 -: PAL_W];
            rom_addr = {1'b0, tile_now};
            rom_re   = 1'b1;
        end
        if (q.s3) begin
            d.lo     = rom_rdata;
            rom_addr = {1'b1, q.tile_a};
            rom_re   = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign word_vld = q.s4;
    assign word     = {rom_rdata, q.lo};
    assign pal      = q.pal;

    assert_hi_after_lo_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_re && !rom_addr[RA-1]) |=> (rom_re && rom_addr == ($past(rom_addr) | (RA'(1) << (RA-1)))));
    assert_single_plane_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(attr_vld && q.s3));
endmodule

// File: rtl/pf_serializer.sv
module pf_serializer #(
    parameter int PAL_W = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        word_vld,
    input  logic [pf_pkg::WORD_W-1:0]   word,
    input  logic [PAL_W-1:0]            pal,
    output logic [PAL_W+pf_pkg::PIX_BITS-1:0] pix_index,
    output logic                        pix_valid
);
    import pf_pkg::*;
    localparam int PW = (PIX_PER_CH > 1) ? $clog2(PIX_PER_CH) : 1;
    localparam logic [PW-1:0] LAST = PW'(PIX_PER_CH - 1);

    typedef struct packed {
        logic             valid;
        logic [PW-1:0]    pos;
        logic [PAL_W-1:0] pal;
        pix_group_t       pix;
    } sr_t;

    sr_t q, d;
    pix_group_t shuf;

    for (genvar p = 0; p < PIX_PER_CH; p++) begin : g_pix
        assign shuf[p] = {word[p+4], word[p], word[p+12], word[p+8]};
    end

    always_comb begin
        d = q;
        if (q.valid) begin
            if (q.pos == LAST) d.valid = 1'b0;
            else               d.pos   = PW'(q.pos + 1'b1);
        end
        if (word_vld) begin
            d.valid = 1'b1;
            d.pos   = '0;
            d.pal   = pal;
            d.pix   = shuf;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pix_valid = q.valid;
    assign pix_index = q.valid ? {q.pal, q.pix[q.pos]} : '0;

    assert_no_overlap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |-> (!q.valid || q.pos == LAST));
    assert_run_unbroken_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.valid && q.pos != LAST) |=> (pix_valid && q.pos == PW'($past(q.pos) + 1'b1)));
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!pix_valid && pix_index == '0));
endmodule

// File: rtl/charrow_pixel_fetch.sv
module charrow_pixel_fetch #(
    parameter int VRAM_AW  = 13,
    parameter int ATTR_OFS = 4096,
    parameter int COLS     = 80,
    parameter int LINE_W   = 3,
    parameter int CODE_W   = 8,
    parameter int BANK_W   = 4,
    parameter int PAL_W    = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [VRAM_AW-1:0]        row_base,
    input  logic [LINE_W-1:0]         line_in,
    input  logic                      row_start,
    input  logic                      char_stb,
    output logic [VRAM_AW-1:0]        vram_addr,
    output logic                      vram_re,
    input  logic [7:0]                vram_rdata,
    output logic [BANK_W+CODE_W+LINE_W:0] rom_addr,
    output logic                      rom_re,
    input  logic [7:0]                rom_rdata,
    output logic [PAL_W+pf_pkg::PIX_BITS-1:0] pix_index,
    output logic                      pix_valid
);
    logic                       attr_vld;
    logic [7:0]                 attr;
    logic [CODE_W-1:0]          code;
    logic [LINE_W-1:0]          line;
    logic                       word_vld;
    logic [pf_pkg::WORD_W-1:0]  word;
    logic [PAL_W-1:0]           pal;

    pf_addr_gen #(
        .VA(VRAM_AW), .COLS(COLS), .LW(LINE_W), .CW(CODE_W), .ATTR_OFS(ATTR_OFS)
    ) u_addr (
        .clk(clk), .rst_n(rst_n), .row_base(row_base), .line_in(line_in),
        .row_start(row_start), .char_stb(char_stb), .vram_rdata(vram_rdata),
        .vram_addr(vram_addr), .vram_re(vram_re), .attr_vld(attr_vld),
        .attr(attr), .code(code), .line(line)
    );

    pf_rom_stage #(
        .LW(LINE_W), .CW(CODE_W), .BANK_W(BANK_W), .PAL_W(PAL_W)
    ) u_rom (
        .clk(clk), .rst_n(rst_n), .attr_vld(attr_vld), .attr(attr),
        .code(code), .line(line), .rom_rdata(rom_rdata),
        .rom_addr(rom_addr), .rom_re(rom_re), .word_vld(word_vld),
        .word(word), .pal(pal)
    );

    pf_serializer #(
        .PAL_W(PAL_W)
    ) u_ser (
        .clk(clk), .rst_n(rst_n), .word_vld(word_vld), .word(word), .pal(pal),
        .pix_index(pix_index), .pix_valid(pix_valid)
    );
endmodule

// File: tb/charrow_pixel_fetch_bench.sv
module charrow_pixel_fetch_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] row_base = '0;
    logic [2:0]  line_in = '0;
    logic        row_start = 1'b0;
    logic        char_stb = 1'b0;
    logic [12:0] vram_addr;
    logic        vram_re;
    logic [7:0]  vram_rdata;
    logic [15:0] rom_addr;
    logic        rom_re;
    logic [7:0]  rom_rdata;
    logic [7:0]  pix_index;
    logic        pix_valid;

    int cyc = 0;
    int n_cmp = 0;
    int n_bad = 0;
    int exp_due[$];
    int exp_val[$];
    int base_m = 0;
    int col_m = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    charrow_pixel_fetch u_charrow_pixel_fetch (
        .clk(clk), .rst_n(rst_n), .row_base(row_base), .line_in(line_in),
        .row_start(row_start), .char_stb(char_stb), .vram_addr(vram_addr),
        .vram_re(vram_re), .vram_rdata(vram_rdata), .rom_addr(rom_addr),
        .rom_re(rom_re), .rom_rdata(rom_rdata), .pix_index(pix_index),
        .pix_valid(pix_valid)
    );

    function automatic int vf(input int a);
        return ((a * 73) + ((a >> 4) * 29) + 53 + (a >> 9)) & 255;
    endfunction
    function automatic int rf(input int a);
        return ((a * 151) ^ ((a >> 8) * 57) ^ 195) & 255;
    endfunction

    always @(posedge clk) begin
        vram_rdata <= 8'(vf(int'(vram_addr)));
        rom_rdata  <= 8'(rf(int'(rom_addr)));
    end

    task automatic note_bad(input string what, input int act, input int expv);
        n_bad++;
        $display("FAIL %s: actual %0h expected %0h (cycle %0d)", what, act, expv, cyc);
    endtask

    // reference compare on every negedge
    always @(negedge clk) begin
        n_cmp++;
        if (exp_due.size() > 0 && exp_due[0] == cyc) begin
            if (pix_valid !== 1'b1)
                note_bad("R7 R8 pix_valid", int'(pix_valid), 1);
            else if (pix_index !== 8'(exp_val[0]))
                note_bad("R5 R6 R4 R9 pix_index", int'(pix_index), exp_val[0]);
            void'(exp_due.pop_front());
            void'(exp_val.pop_front());
        end else if (pix_valid !== 1'b0 || pix_index !== 8'h00) begin
            note_bad("R1 R7 idle output", int'({pix_valid, pix_index}), 0);
        end
    end

    task automatic put_char(input bit rs, input int base, input int ln, input int gap);
        int off, aoff, code, attr, tile, ra, w, px;
        @(negedge clk);
        if (rs) begin base_m = base & 8191; col_m = 0; end
        off  = (base_m + col_m + 1) % 8192;
        aoff = (off + 4096) % 8192;
        code = vf(off);
        attr = vf(aoff);
        tile = ((attr & 15) << 8) | code;
        ra   = (tile << 3) | (ln & 7);
        w    = (rf(ra | 32768) << 8) | rf(ra);
        for (int n = 0; n < 4; n++) begin
            px = (((w >> (n + 4)) & 1) << 3) | (((w >> n) & 1) << 2) |
                 (((w >> (n + 12)) & 1) << 1) | ((w >> (n + 8)) & 1);
            exp_due.push_back(cyc + 5 + n);
            exp_val.push_back(((attr >> 4) << 4) | px);
        end
        row_start = rs;
        row_base  = 13'(base);
        line_in   = 3'(ln);
        char_stb  = 1'b1;
        #1;
        n_cmp++;
        if (vram_addr !== 13'(off) || vram_re !== 1'b1)
            note_bad("R2 R10 code offset", int'(vram_addr), off);
        @(negedge clk);
        char_stb  = 1'b0;
        row_start = 1'b0;
        row_base  = 13'(base ^ 13'h1555);
        line_in   = 3'(ln + 3);
        #1;
        n_cmp++;
        if (vram_addr !== 13'(aoff) || vram_re !== 1'b1)
            note_bad("R3 attribute offset", int'(vram_addr), aoff);
        @(negedge clk);
        n_cmp++;
        if (rom_addr !== 16'(ra) || rom_re !== 1'b1)
            note_bad("R4 low plane address", int'(rom_addr), ra);
        @(negedge clk);
        n_cmp++;
        if (rom_addr !== 16'(ra | 32768) || rom_re !== 1'b1)
            note_bad("R4 high plane address", int'(rom_addr), ra | 32768);
        col_m = (col_m + 1) % 80;
        repeat (gap - 4) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        note_bad("R7 watchdog expired", cyc, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        n_cmp++;
        if (vram_re !== 1'b0 || rom_re !== 1'b0)
            note_bad("R1 reset read enables", int'({vram_re, rom_re}), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R2 R7: single characters, isolated
        put_char(1'b1, 0, 0, 12);
        put_char(1'b0, 0, 0, 12);
        // R8: back-to-back row
        for (int i = 0; i < 6; i++) put_char(i == 0, 13'h0123, 5, 4);
        // R9: spaced strobes, new line per character
        for (int i = 0; i < 6; i++) put_char(i == 0, 13'h0abc, i, 6);
        // R2 R3: offsets wrap at the top of the space
        for (int i = 0; i < 10; i++) put_char(i == 0, 13'h1ffd, 7, 4);
        // R10: 81 characters in one row
        for (int i = 0; i < 81; i++) put_char(i == 0, 13'h0f80, 3, 4);
        // mixed rows
        for (int r = 0; r < 16; r++)
            for (int i = 0; i < 8; i++)
                put_char(i == 0, (r * 977) & 8191, r & 7, (r % 3 == 0) ? 5 : 4);
        repeat (20) @(negedge clk);
        n_cmp++;
        if (exp_due.size() != 0)
            note_bad("R7 pixels never delivered", exp_due.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule